// File: doc/BRIEF.md
# Dual-Mode Sequential Unsigned Divider

This block divides one unsigned WIDTH-bit operand by another over several clock cycles and returns a WIDTH-bit quotient and a WIDTH-bit remainder. It works on three registers. The partial remainder is one bit wider than the operands. A second register first holds the dividend and collects quotient bits as they are formed. The third holds the divisor. Each pass of the loop moves the partial remainder and the dividend register left by one place and produces one quotient bit.

A mode input chosen at the start of each operation sets the iteration scheme. The restoring scheme undoes any subtraction that goes negative. The non-restoring scheme carries a negative partial remainder into the next pass, adds the divisor instead of subtracting it, and repairs the remainder in one extra cycle at the end. Both schemes must give the same result. A request carries a start pulse. The block raises busy while it works and gives a one-cycle done pulse when the results are ready. A zero divisor is reported through a flag and skips the loop.

Top module: `seq_divider`

## Requirements
- R1: After reset, busy_o, done_o, div_by_zero_o, quotient_o and remainder_o are all zero.
- R2: With mode_i = 0 (restoring) and a non-zero divisor, quotient_o = dividend / divisor and remainder_o = dividend % divisor when done_o is high.
- R3: With mode_i = 1 (non-restoring) and a non-zero divisor, quotient_o and remainder_o equal the floor quotient and the remainder. For every operand pair they are identical to the restoring results, the final correction included.
- R4: Count the rising edges from the one that samples start_i up to the one after which done_o is high, both included. The count is WIDTH+1 in restoring mode, WIDTH+2 in non-restoring mode, and 1 for a zero divisor.
- R5: busy_o is high from the edge that accepts start_i until done_o is high. done_o lasts exactly one cycle.
- R6: A zero divisor sets div_by_zero_o, gives an all-ones quotient and returns the dividend as the remainder. Any other divisor leaves div_by_zero_o low.
- R7: While busy_o is high, start_i, mode_i, dividend_i and divisor_i have no effect on the running operation's results or its latency.
- R8: After done_o, quotient_o, remainder_o and div_by_zero_o hold their values until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; sampled while idle |
| mode_i | input | 1 | 0 = restoring, 1 = non-restoring; sampled with start_i |
| dividend_i | input | WIDTH | Dividend |
| divisor_i | input | WIDTH | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse; results valid |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |
| div_by_zero_o | output | 1 | Divisor was zero on the last operation |

## Verification
The results are due a fixed number of edges after the accepting edge: WIDTH+1 for restoring, WIDTH+2 for non-restoring and 1 for a zero divisor. The bench counts edges from the accepting edge and samples each output at the falling edge that follows. It then compares the count it measured with the count it expects for the mode. The sweep covers every operand pair in both modes at WIDTH = 4. Each result is compared with the / and % operators and with the result of the other mode. Directed cases check that done_o drops one cycle later, that the results stay unchanged while the block is idle, and that a request made during an operation has no effect.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } div_state_e;
endpackage

// File: rtl/div_step.sv
// One iteration of either scheme on the A/Q/M register set.
module div_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   a_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic             nonrest_i,
  output logic [WIDTH:0]   a_o,
  output logic [WIDTH-1:0] q_o
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0] a_sh, m_ext, a_sum, a_dif;
  logic          q_bit;

  assign a_sh  = {a_i[WIDTH-1:0], q_i[WIDTH-1]};
  assign m_ext = {1'b0, m_i};
  assign a_sum = a_sh + m_ext;
  assign a_dif = a_sh - m_ext;

  always_comb begin
    if (nonrest_i) begin
      a_o   = a_i[WIDTH] ? a_sum : a_dif;
      q_bit = ~a_o[WIDTH];
    end else begin
      // negative difference: keep the shifted value (restore)
      a_o   = a_dif[WIDTH] ? a_sh : a_dif;
      q_bit = ~a_dif[WIDTH];
    end
  end

  assign q_o = {q_i[WIDTH-2:0], q_bit};
endmodule

// File: rtl/div_fixup.sv
// Final remainder correction for the non-restoring scheme.
module div_fixup #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   a_i,
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH:0]   a_o
);
  assign a_o = a_i[WIDTH] ? (a_i + {1'b0, m_i}) : a_i;
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  input  logic zero_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic nonrest_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign step_o    = (state_q == ST_RUN);
  assign fix_o     = (state_q == ST_FIX);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign nonrest_o = mode_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = zero_i ? ST_DONE : ST_RUN;
      ST_RUN:  if (cnt_q == LAST) state_d = mode_q ? ST_FIX : ST_DONE;
      ST_FIX:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        cnt_q  <= '0;
        mode_q <= mode_i;
      end else if (step_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> busy_o); // R5
  AST_RUN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cnt_q == LAST) |=> !step_o); // R4
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(nonrest_o)); // R7
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o,
  output logic             div_by_zero_o
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    a_q, a_step, a_fix;
  logic [WIDTH-1:0] q_q, q_step, m_q;
  logic             dz_q, zero_in;
  logic             load, step, fix, nonrest;

  assign zero_in = (divisor_i == '0);

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .zero_i    (zero_in),
    .load_o    (load),
    .step_o    (step),
    .fix_o     (fix),
    .nonrest_o (nonrest),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  div_step #(.WIDTH(WIDTH)) u_step (
    .a_i       (a_q),
    .q_i       (q_q),
    .m_i       (m_q),
    .nonrest_i (nonrest),
    .a_o       (a_step),
    .q_o       (q_step)
  );

  div_fixup #(.WIDTH(WIDTH)) u_fix (
    .a_i (a_q),
    .m_i (m_q),
    .a_o (a_fix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= '0;
      q_q  <= '0;
      m_q  <= '0;
      dz_q <= 1'b0;
    end else if (load) begin
      m_q  <= divisor_i;
      dz_q <= zero_in;
      if (zero_in) begin
        a_q <= {1'b0, dividend_i};
        q_q <= '1;
      end else begin
        a_q <= '0;
        q_q <= dividend_i;
      end
    end else if (step) begin
      a_q <= a_step;
      q_q <= q_step;
    end else if (fix) begin
      a_q <= a_fix;
    end
  end

  assign quotient_o    = q_q;
  assign remainder_o   = a_q[WIDTH-1:0];
  assign div_by_zero_o = dz_q;

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dz_q) |-> (!a_q[WIDTH] && remainder_o < m_q)); // R2
  AST_DZ_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dz_q) |-> (quotient_o == '1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_by_zero_o))); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(m_q)); // R7
endmodule

// File: tb/sim_seq_divider.sv
`timescale 1ns/1ps
module sim_seq_divider;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic busy_o, done_o, div_by_zero_o;
  logic [W-1:0] quotient_o, remainder_o;

  int checks = 0;
  int failures = 0;
  int res_q [N][N];
  int res_r [N][N];

  always #2.5 clk_i = ~clk_i;

  seq_divider #(.WIDTH(W)) u0 (
    .clk_i, .rst_ni, .start_i, .mode_i, .dividend_i, .divisor_i,
    .busy_o, .done_o, .quotient_o, .remainder_o, .div_by_zero_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Launches one operation; returns the edge count until done (R4).
  task automatic run_op(input int dvd, input int dvs, input bit md,
                        input bit poke, output int lat);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = md;
    dividend_i = W'(dvd); divisor_i = W'(dvs);
    @(posedge clk_i);
    lat = 1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R5 busy after accept", busy_o, 1);
    if (poke) begin
      // R7: new request with other operands and mode while busy
      start_i = 1'b1; mode_i = ~md; dividend_i = 7; divisor_i = 0;
    end
    while (!done_o && lat < 64) begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      start_i = 1'b0;
      if (!done_o) chk(busy_o == 1'b1, "R5 busy until done", busy_o, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk_i);
    // R1
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(done_o == 0, "R1 done", done_o, 0);
    chk(div_by_zero_o == 0, "R1 dz", div_by_zero_o, 0);
    chk(quotient_o == 0, "R1 quotient", quotient_o, 0);
    chk(remainder_o == 0, "R1 remainder", remainder_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int md = 0; md < 2; md++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          run_op(a, b, md[0], 1'b0, lat);
          if (b == 0) begin
            chk(lat == 1, "R4 latency zero divisor", lat, 1);
            chk(div_by_zero_o == 1, "R6 flag", div_by_zero_o, 1);
            chk(quotient_o == W'(N - 1), "R6 quotient", quotient_o, N - 1);
            chk(remainder_o == W'(a), "R6 remainder", remainder_o, a);
          end else if (md == 0) begin
            chk(lat == W + 1, "R4 latency restoring", lat, W + 1);
            chk(div_by_zero_o == 0, "R6 flag low", div_by_zero_o, 0);
            chk(quotient_o == W'(a / b), "R2 quotient", quotient_o, a / b);
            chk(remainder_o == W'(a % b), "R2 remainder", remainder_o, a % b);
            res_q[a][b] = quotient_o;
            res_r[a][b] = remainder_o;
          end else begin
            chk(lat == W + 2, "R4 latency non-restoring", lat, W + 2);
            chk(div_by_zero_o == 0, "R6 flag low", div_by_zero_o, 0);
            chk(quotient_o == W'(a / b), "R3 quotient", quotient_o, a / b);
            chk(remainder_o == W'(a % b), "R3 remainder", remainder_o, a % b);
            chk(int'(quotient_o) == res_q[a][b], "R3 quotient vs restoring", quotient_o, res_q[a][b]);
            chk(int'(remainder_o) == res_r[a][b], "R3 remainder vs restoring", remainder_o, res_r[a][b]);
          end
          @(negedge clk_i);
          chk(done_o == 0, "R5 done one cycle", done_o, 0);
        end
      end
    end

    // R7: ignored request while busy, both modes
    for (int md = 0; md < 2; md++) begin
      run_op(13, 3, md[0], 1'b1, lat);
      chk(lat == W + 1 + md, "R7 latency unaffected", lat, W + 1 + md);
      chk(quotient_o == 4, "R7 quotient", quotient_o, 4);
      chk(remainder_o == 1, "R7 remainder", remainder_o, 1);
      chk(div_by_zero_o == 0, "R7 flag", div_by_zero_o, 0);
    end

    // R8: results stay while idle
    run_op(15, 2, 1'b1, 1'b0, lat);
    dividend_i = 3; divisor_i = 0; mode_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0, "R8 idle", busy_o, 0);
    chk(quotient_o == 7, "R8 quotient held", quotient_o, 7);
    chk(remainder_o == 1, "R8 remainder held", remainder_o, 1);
    chk(div_by_zero_o == 0, "R8 flag held", div_by_zero_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule